// File: doc/BRIEF.md
# Event Interrupt Controller with Write-Masked Registers

This block gathers sixteen single-cycle event pulses from a display pipeline and keeps each one pending until software acknowledges it. Software reaches the block through a plain 32-bit register port. The port has four registers: the enable bits, a clear (acknowledge) register, the pending events filtered by the enables, and the unfiltered pending events. A single registered interrupt line is asserted while any enabled event is pending.

The enable and clear registers are written with a per-bit mask. The upper half-word of the write data selects the bits to update, and the lower half-word holds their new values. This lets two independent software paths change different bits without a read-modify-write sequence. Event bit positions follow a fixed assignment:

| Bit | Event |
|-----|-------|
| 0 | frame start |
| 1 | new frame start |
| 2 | address-same |
| 3, 4 | line flags |
| 5 | bus error |
| 6 to 9 | window empty |
| 10 | cursor empty |
| 11 | post-buffer empty |
| 12 | field frame start |
| 13 | display-hold-valid |
| 14 | MMU |
| 15 | DMA finish |

Bit i of the event input always appears as bit i of both status registers.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the enable, masked-status and raw-status registers all read zero, and `irq_o` is low.
- R2: A high `evt_i[i]` in a cycle sets raw bit i at the next clock edge. The bit stays set in every later cycle until it is cleared.
- R3: A write to offset 0x280 updates enable bit i to `wdata_i[i]` only where `wdata_i[16+i]` is 1. Every other enable bit keeps its value. A read of 0x280 returns the enables in bits 15:0 and zero in bits 31:16.
- R4: A write to 0x280 with `wdata_i[31:16]` equal to zero leaves every enable bit unchanged, whatever the value in the lower half.
- R5: A write to offset 0x284 clears raw bit i when both `wdata_i[16+i]` and `wdata_i[i]` are 1. A mask bit of 1 with a value bit of 0, or a mask bit of 0 with a value bit of 1, leaves bit i pending.
- R6: When an event pulse on bit i and a clear of bit i arrive in the same cycle, bit i is pending after that edge.
- R7: A read of 0x288 returns raw AND enable in bits 15:0. A read of 0x28C returns the raw pending bits regardless of the enables. Bits 31:16 of both reads are zero.
- R8: `irq_o` is a register output. After every clock edge it equals the OR of (raw AND enable) as held after that edge.
- R9: Reads of the clear offset 0x284, and of any offset other than the four registers, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | One-cycle event pulses, bit i is event i |
| wr_i | input | 1 | Register write strobe for this cycle |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data: mask in 31:16, value in 15:0 for enable and clear |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the write strobe selects at most one register per cycle, and that every event is a clean one-cycle pulse sampled at the clock. Neither the stickiness check nor the priority check depends on pulse width, so an event held high only re-sets a bit that is already pending. The stimulus always drives inputs a half period away from the sampling edge. It mixes directed cases that collide a clear with an event on the same bit with a long run of sparse random pulses and random masked writes to both writable registers.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int WORD_W = 32;
    localparam int EVT_W  = 16;
    localparam int OFS_W  = 12;

    localparam logic [OFS_W-1:0] OFS_EN   = 12'h280;
    localparam logic [OFS_W-1:0] OFS_CLR  = 12'h284;
    localparam logic [OFS_W-1:0] OFS_STAT = 12'h288;
    localparam logic [OFS_W-1:0] OFS_RAW  = 12'h28C;

    typedef logic [EVT_W-1:0] evt_t;

    typedef struct packed {
        logic en_wr;
        logic clr_wr;
        logic rd_en;
        logic rd_stat;
        logic rd_raw;
    } dec_t;

    typedef struct packed {
        evt_t en;
        logic irq;
    } ctl_t;
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
    import evt_irq_pkg::*;
(
    input  logic             wr_i,
    input  logic [OFS_W-1:0] addr_i,
    output dec_t             dec_o
);
    always_comb begin
        dec_o         = '0;
        dec_o.en_wr   = wr_i && (addr_i == OFS_EN);
        dec_o.clr_wr  = wr_i && (addr_i == OFS_CLR);
        dec_o.rd_en   = (addr_i == OFS_EN);
        dec_o.rd_stat = (addr_i == OFS_STAT);
        dec_o.rd_raw  = (addr_i == OFS_RAW);
    end
endmodule

// File: rtl/evt_irq_wmask.sv
module evt_irq_wmask #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] merged_o,
    output logic [W-1:0] hit_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign merged_o[i] = mask_i[i] ? val_i[i] : cur_i[i];
        assign hit_o[i]    = mask_i[i] & val_i[i];
    end
endmodule

// File: rtl/evt_irq_pend.sv
module evt_irq_pend
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt_i,
    input  evt_t clr_hit_i,
    output evt_t raw_nxt_o,
    output evt_t raw_o
);
    evt_t raw_d, raw_q;

    always_comb begin
        raw_d = raw_q;
        for (int i = 0; i < EVT_W; i++) begin
            if (clr_hit_i[i]) raw_d[i] = 1'b0;
            if (evt_i[i])     raw_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw_nxt_o = raw_d;
    assign raw_o     = raw_q;

    // R2
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_q) & ~$past(clr_hit_i) & ~raw_q) == '0));

    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_i) & ~raw_q) == '0));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              wr_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int PAD_W = WORD_W - EVT_W;

    dec_t dec;
    evt_t wmask, wval, en_merged, wr_hit, clr_hit, raw_nxt, raw_q;
    ctl_t ctl_d, ctl_q;

    assign wmask = wdata_i[EVT_W +: EVT_W];
    assign wval  = wdata_i[0 +: EVT_W];

    evt_irq_decode u_dec (
        .wr_i   (wr_i),
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    evt_irq_wmask #(.W(EVT_W)) u_wm (
        .cur_i    (ctl_q.en),
        .mask_i   (wmask),
        .val_i    (wval),
        .merged_o (en_merged),
        .hit_o    (wr_hit)
    );

    assign clr_hit = dec.clr_wr ? wr_hit : '0;

    evt_irq_pend u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .clr_hit_i (clr_hit),
        .raw_nxt_o (raw_nxt),
        .raw_o     (raw_q)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.en  = dec.en_wr ? en_merged : ctl_q.en;
        ctl_d.irq = |(raw_nxt & ctl_d.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata_o = '0;
        if (dec.rd_en)        rdata_o = {{PAD_W{1'b0}}, ctl_q.en};
        else if (dec.rd_stat) rdata_o = {{PAD_W{1'b0}}, raw_q & ctl_q.en};
        else if (dec.rd_raw)  rdata_o = {{PAD_W{1'b0}}, raw_q};
    end

    assign irq_o = ctl_q.irq;

    // R8
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |(raw_q & ctl_q.en)));

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == OFS_EN && wmask != '0) |=> $stable(ctl_q.en));

    // R3
    en_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_EN) |=>
            (((ctl_q.en ^ $past(ctl_q.en)) & ~$past(wmask)) == '0));
endmodule

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;
    localparam int CLK_P = 10;
    localparam logic [11:0] A_EN = 12'h280, A_CLR = 12'h284,
                            A_STAT = 12'h288, A_RAW = 12'h28C, A_NONE = 12'h290;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [15:0] m_raw = '0, m_en = '0;

    always #(CLK_P/2) clk = ~clk;

    evt_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        logic [15:0] nr;
        if (!rst_n) begin
            m_raw = '0; m_en = '0;
        end else begin
            nr = m_raw;
            if (wr && addr == A_CLR) nr = nr & ~(wdata[31:16] & wdata[15:0]);
            nr = nr | evt;
            if (wr && addr == A_EN)
                m_en = (m_en & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]);
            m_raw = nr;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R8: interrupt line versus model every cycle
    always @(negedge clk) begin
        if (rst_n && !finished)
            chk(irq == |(m_raw & m_en), "R8", {31'b0, irq}, {31'b0, |(m_raw & m_en)});
    end

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        case (a)
            A_EN:    return {16'h0, m_en};
            A_STAT:  return {16'h0, m_raw & m_en};
            A_RAW:   return {16'h0, m_raw};
            default: return 32'h0;
        endcase
    endfunction

    task automatic step(input logic [15:0] e, input bit w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        evt = e; wr = w; addr = a; wdata = d;
        @(negedge clk);
        evt = '0; wr = 1'b0; wdata = '0;
    endtask

    task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(rdata === exp, tag, rdata, exp);
        chk(rdata === model_rd(a), {tag, "-model"}, rdata, model_rd(a));
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rdchk(A_EN, 32'h0, "R1");
        rdchk(A_STAT, 32'h0, "R1");
        rdchk(A_RAW, 32'h0, "R1");
        chk(irq == 1'b0, "R1", {31'b0, irq}, 32'h0);

        // R2: new-frame pulse latches and stays
        step(16'h0002, 0, A_RAW, 32'h0);
        rdchk(A_RAW, 32'h2, "R2");
        repeat (3) @(negedge clk);
        rdchk(A_RAW, 32'h2, "R2");
        rdchk(A_STAT, 32'h0, "R7");
        chk(irq == 1'b0, "R8", {31'b0, irq}, 32'h0);

        // R3: masked enable write
        step(16'h0, 1, A_EN, 32'h0002_0002);
        rdchk(A_EN, 32'h2, "R3");
        rdchk(A_STAT, 32'h2, "R7");
        chk(irq == 1'b1, "R8", {31'b0, irq}, 32'h1);

        // R4: zero mask changes nothing
        step(16'h0, 1, A_EN, 32'h0000_FFFF);
        rdchk(A_EN, 32'h2, "R4");

        step(16'h0, 1, A_EN, 32'h00F0_0050);
        rdchk(A_EN, 32'h52, "R3");

        // R5: clear needs mask and value
        step(16'h0, 1, A_CLR, 32'h0002_0000);
        rdchk(A_RAW, 32'h2, "R5");
        step(16'h0, 1, A_CLR, 32'h0000_0002);
        rdchk(A_RAW, 32'h2, "R5");
        step(16'h0, 1, A_CLR, 32'h0002_0002);
        rdchk(A_RAW, 32'h0, "R5");
        chk(irq == 1'b0, "R8", {31'b0, irq}, 32'h0);

        // R6: event beats a same-cycle clear
        step(16'h0010, 0, A_RAW, 32'h0);
        rdchk(A_STAT, 32'h10, "R7");
        step(16'h0010, 1, A_CLR, 32'h0010_0010);
        rdchk(A_RAW, 32'h10, "R6");
        step(16'h0, 1, A_CLR, 32'h0010_0010);
        rdchk(A_RAW, 32'h0, "R5");

        // R9 with everything pending
        step(16'hFFFF, 0, A_RAW, 32'h0);
        rdchk(A_CLR, 32'h0, "R9");
        rdchk(A_NONE, 32'h0, "R9");
        rdchk(A_RAW, 32'h0000_FFFF, "R7");
        rdchk(A_STAT, 32'h52, "R7");
        step(16'h0, 1, A_EN, 32'hFFFF_FFFF);
        rdchk(A_EN, 32'h0000_FFFF, "R3");
        step(16'h0, 1, A_CLR, 32'hFFFF_FFFF);
        rdchk(A_RAW, 32'h0, "R5");

        // random traffic compared against the model
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] ra;
            @(negedge clk);
            evt = ($urandom % 4 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            case ($urandom % 6)
                0: begin wr = 1'b1; addr = A_EN;  wdata = $urandom; end
                1: begin wr = 1'b1; addr = A_CLR; wdata = $urandom; end
                default: begin
                    wr = 1'b0; wdata = '0;
                    case ($urandom % 3)
                        0: ra = A_EN;
                        1: ra = A_STAT;
                        default: ra = A_RAW;
                    endcase
                    addr = ra;
                end
            endcase
            #1;
            chk(rdata === model_rd(addr), "R7", rdata, model_rd(addr));
        end
        @(negedge clk);
        evt = '0; wr = 1'b0;
        @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule